// File: doc/BRIEF.md
# SPI Serial Memory Front-End with Region Write Guard

This block is the command and control logic of a 32K x 8 serial memory behind an SPI slave port. It decodes the serial command stream and holds a write enable latch and a status register. It gathers write data into a one-page buffer and then runs a timed internal write cycle. During that cycle it moves the buffered bytes into an external byte-wide array. It also compares every target address against a protected region that starts at address zero. A pause input freezes the serial transfer, and a lock pin can freeze the protection setting.

All serial inputs are brought into the system clock domain by two-flop synchronizers. Both SCK edges are detected in that domain, so SPI modes 0 and 3 both work without any change. Reads from the array take a combinational or pre-registered data word from the array model. Writes go to it one byte per clock during the busy window.

Top module: `spi_eeprom_guard`

## Requirements
- R1: After reset the status byte reads 0x00, `so_en` is low and `mem_we` is low.
- R2: The status byte is laid out as: bit 0 busy, bit 1 write latch, bits 4:2 region code, bit 7 lock-pin enable, bits 6:5 zero. Opcode 0x06 sets the write latch, opcode 0x04 clears it, and opcode 0x05 returns the status byte.
- R3: A data write (opcode 0x02, then the address high byte, the address low byte and the data) made while the write latch is clear changes no array byte.
- R4: Write data bytes fill consecutive addresses. The low 6 address bits wrap inside the 64-byte page, and the page number stays fixed.
- R5: An accepted write sets busy for exactly WR_CYCLES clocks after chip select rises. While busy, every opcode except 0x05 is ignored, and that includes 0x06.
- R6: Region codes protect these address ranges, all starting at zero: 0 none, 1 below 0x40, 2 below 0x80, 3 below 0x100, 4 below 0x200, 5 below 0x2000, 6 below 0x4000, 7 the whole array. A write frame that touches a protected byte writes nothing and starts no busy window.
- R7: The write latch is cleared when chip select rises after any status-write or data-write frame, whether the write was accepted or rejected.
- R8: A status write (opcode 0x01, then one byte) updates bits 7 and 4:2. It is rejected while bit 7 is set and `wp_n` is low. When bit 7 is clear, `wp_n` has no effect.
- R9: A read (opcode 0x03 plus address) returns the array bytes from that address upward on SO, most significant bit first, and keeps going across page boundaries. It works in both SPI mode 0 and SPI mode 3.
- R10: While `hold_n` is low, SCK and SI transitions are ignored, and the transfer continues from the same bit once `hold_n` rises.
- R11: `so_en` is high only while chip select is low and `hold_n` is high.
- R12: The array is written only during the busy window, and only at the bytes that were received in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Transfer pause, active low |
| wp_n | input | 1 | Lock pin for status writes, active low |
| so | output | 1 | Serial data out |
| so_en | output | 1 | SO drive enable |
| mem_addr | output | ADDR_W | Array byte address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write strobe, one byte per clock |
| mem_rdata | input | 8 | Array read data at `mem_addr` |

## Verification
Each pin passes through two synchronizer flops and one edge-detect register. An SCK edge therefore reaches SO, or the frame state, on the third clock after it, and a chip-select rise sets busy on the third clock. The bench holds each SCK level for 8 clocks and reads SO on the clock just before it raises SCK, which is well after the falling edge that shifted that bit out. The busy window is checked twice with status reads: one made directly after the write frame, which must show busy, and one made WR_CYCLES+20 clocks later, which must show idle. Array effects are counted at the bench memory, so a rejected write shows up as zero strobes.

// File: rtl/spi_eeprom_guard_pkg.sv
package spi_eeprom_guard_pkg;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_WRSR  = 8'h01;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRITE = 8'h02;

    typedef enum logic [2:0] {
        PH_CMD, PH_ADDR_HI, PH_ADDR_LO, PH_DATA, PH_SKIP
    } phase_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE
    } op_t;

    typedef struct packed {
        logic       lock_en;
        logic [2:0] region;
        logic       wel;
        logic       busy;
    } status_t;

    function automatic logic [7:0] pack_status(status_t s);
        return {s.lock_en, 2'b00, s.region, s.wel, s.busy};
    endfunction

    // Number of bytes protected from address zero for a region code.
    function automatic int unsigned region_bytes(logic [2:0] code, int addr_w, int page_w);
        case (code)
            3'd1:    return 32'd1 << page_w;
            3'd2:    return 32'd2 << page_w;
            3'd3:    return 32'd4 << page_w;
            3'd4:    return 32'd8 << page_w;
            3'd5:    return 32'd1 << (addr_w - 2);
            3'd6:    return 32'd1 << (addr_w - 1);
            3'd7:    return 32'd1 << addr_w;
            default: return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/spi_eeprom_guard_sync.sv
module spi_eeprom_guard_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/spi_eeprom_guard_region.sv
module spi_eeprom_guard_region
    import spi_eeprom_guard_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        code,
    output logic              hit
);
    always_comb hit = 32'(addr) < region_bytes(code, ADDR_W, PAGE_W);
endmodule

// File: rtl/spi_eeprom_guard_pgbuf.sv
module spi_eeprom_guard_pgbuf #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [7:0]        rd_data,
    output logic              rd_mask
);
    localparam int PAGE_B = 1 << PAGE_W;

    logic [7:0]        bytes_q [PAGE_B];
    logic [PAGE_B-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            mask_q <= '0;
        else if (wr_en)
            mask_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            bytes_q[wr_idx] <= wr_data;
    end

    assign rd_data = bytes_q[rd_idx];
    assign rd_mask = mask_q[rd_idx];
endmodule

// File: rtl/spi_eeprom_guard.sv
module spi_eeprom_guard
    import spi_eeprom_guard_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int PAGE_W    = 6,
    parameter int WR_CYCLES = 1_250_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_n,
    input  logic              wp_n,
    output logic              so,
    output logic              so_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata
);
    localparam int PAGE_B = 1 << PAGE_W;
    localparam int CNT_W  = $clog2(WR_CYCLES + 1);
    localparam int PG_NUM_W = ADDR_W - PAGE_W;

    // synchronized pins
    logic sck_s, cs_s, si_s, hold_s, wp_s;
    logic sck_q, cs_q;

    spi_eeprom_guard_sync #(.W(5), .RST_VAL(5'b01011)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck, cs_n, si, hold_n, wp_n}),
        .q   ({sck_s, cs_s, si_s, hold_s, wp_s})
    );

    logic active, sck_rise, sck_fall, cs_rise, cs_fall;
    assign active   = !cs_s && hold_s;
    assign sck_rise = active && sck_s && !sck_q;
    assign sck_fall = active && !sck_s && sck_q;
    assign cs_rise  = cs_s && !cs_q;
    assign cs_fall  = !cs_s && cs_q;

    // status register
    logic       busy, wel, lock_en;
    logic [2:0] region;
    status_t    st;
    assign st = '{lock_en: lock_en, region: region, wel: wel, busy: busy};

    // frame state
    phase_t             phase;
    op_t                op;
    logic [2:0]         bit_idx;
    logic [6:0]         rx;
    logic [7:0]         rx_byte;
    logic [ADDR_W-1:0]  addr;
    logic               got, abort;
    logic               new_lock;
    logic [2:0]         new_region;
    logic [6:0]         tx;
    logic [7:0]         tx_byte;
    logic               so_q;

    // write engine
    logic [CNT_W-1:0]    cyc;
    logic                prog_arr;
    logic [PG_NUM_W-1:0] prog_page;

    assign rx_byte = {rx, si_s};
    assign tx_byte = (op == OP_RDSR) ? pack_status(st) : mem_rdata;

    logic prot_hit;
    spi_eeprom_guard_region #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_region (
        .addr (addr),
        .code (region),
        .hit  (prot_hit)
    );

    logic       buf_wr;
    logic [7:0] buf_rd;
    logic       buf_mask;
    assign buf_wr = sck_rise && (bit_idx == 3'd7) && (phase == PH_DATA) && (op == OP_WRITE);

    spi_eeprom_guard_pgbuf #(.PAGE_W(PAGE_W)) u_pgbuf (
        .clk     (clk),
        .rst     (rst),
        .clr     (cs_fall && !busy),
        .wr_en   (buf_wr),
        .wr_idx  (addr[PAGE_W-1:0]),
        .wr_data (rx_byte),
        .rd_idx  (cyc[PAGE_W-1:0]),
        .rd_data (buf_rd),
        .rd_mask (buf_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q      <= 1'b0;
            cs_q       <= 1'b1;
            busy       <= 1'b0;
            wel        <= 1'b0;
            lock_en    <= 1'b0;
            region     <= '0;
            phase      <= PH_CMD;
            op         <= OP_NONE;
            bit_idx    <= '0;
            rx         <= '0;
            addr       <= '0;
            got        <= 1'b0;
            abort      <= 1'b0;
            new_lock   <= 1'b0;
            new_region <= '0;
            tx         <= '0;
            so_q       <= 1'b0;
            cyc        <= '0;
            prog_arr   <= 1'b0;
            prog_page  <= '0;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_s;

            if (busy) begin
                if (cyc == CNT_W'(WR_CYCLES - 1))
                    busy <= 1'b0;
                else
                    cyc <= cyc + CNT_W'(1);
            end

            if (cs_s) begin
                phase   <= PH_CMD;
                op      <= OP_NONE;
                bit_idx <= '0;
                got     <= 1'b0;
                abort   <= 1'b0;
            end else if (sck_rise) begin
                rx      <= rx_byte[6:0];
                bit_idx <= bit_idx + 3'd1;
                if (bit_idx == 3'd7) begin
                    case (phase)
                        PH_CMD: begin
                            if (busy && rx_byte != OPC_RDSR) begin
                                phase <= PH_SKIP;
                            end else begin
                                case (rx_byte)
                                    OPC_WREN:  begin wel <= 1'b1; phase <= PH_SKIP; end
                                    OPC_WRDI:  begin wel <= 1'b0; phase <= PH_SKIP; end
                                    OPC_RDSR:  begin op <= OP_RDSR;  phase <= PH_DATA; end
                                    OPC_WRSR:  begin op <= OP_WRSR;  phase <= PH_DATA; end
                                    OPC_READ:  begin op <= OP_READ;  phase <= PH_ADDR_HI; end
                                    OPC_WRITE: begin op <= OP_WRITE; phase <= PH_ADDR_HI; end
                                    default:   phase <= PH_SKIP;
                                endcase
                            end
                        end
                        PH_ADDR_HI: begin
                            addr[ADDR_W-1:8] <= rx_byte[ADDR_W-9:0];
                            phase <= PH_ADDR_LO;
                        end
                        PH_ADDR_LO: begin
                            addr[7:0] <= rx_byte;
                            phase <= PH_DATA;
                        end
                        PH_DATA: begin
                            if (op == OP_WRITE) begin
                                got <= 1'b1;
                                if (prot_hit)
                                    abort <= 1'b1;
                                addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PAGE_W'(1);
                            end else if (op == OP_WRSR) begin
                                new_lock   <= rx_byte[7];
                                new_region <= rx_byte[4:2];
                                got        <= 1'b1;
                                phase      <= PH_SKIP;
                            end
                        end
                        default: ;
                    endcase
                end
            end else if (sck_fall && phase == PH_DATA && (op == OP_READ || op == OP_RDSR)) begin
                if (bit_idx == 3'd0) begin
                    so_q <= tx_byte[7];
                    tx   <= tx_byte[6:0];
                    if (op == OP_READ)
                        addr <= addr + ADDR_W'(1);
                end else begin
                    so_q <= tx[6];
                    tx   <= {tx[5:0], 1'b0};
                end
            end

            if (cs_rise) begin
                if (op == OP_WRITE) begin
                    wel <= 1'b0;
                    if (wel && got && !abort) begin
                        busy      <= 1'b1;
                        cyc       <= '0;
                        prog_arr  <= 1'b1;
                        prog_page <= addr[ADDR_W-1:PAGE_W];
                    end
                end else if (op == OP_WRSR) begin
                    wel <= 1'b0;
                    if (wel && got && !(lock_en && !wp_s)) begin
                        lock_en  <= new_lock;
                        region   <= new_region;
                        busy     <= 1'b1;
                        cyc      <= '0;
                        prog_arr <= 1'b0;
                    end
                end
            end
        end
    end

    assign so        = so_q;
    assign so_en     = active;
    assign mem_we    = busy && prog_arr && (32'(cyc) < PAGE_B) && buf_mask;
    assign mem_addr  = busy ? {prog_page, cyc[PAGE_W-1:0]} : addr;
    assign mem_wdata = buf_rd;
endmodule

// File: rtl/spi_eeprom_guard_chk.sv
module spi_eeprom_guard_chk #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              so_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              wel,
    input logic              lock_en,
    input logic              wp_s,
    input logic [2:0]        region
);
    p_we_in_busy_r12: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    p_so_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_en);

    p_no_latch_busy_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> !wel);

    p_region_locked_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(lock_en) && !$past(wp_s)) |-> $stable(region));

    p_page_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> $stable(mem_addr[ADDR_W-1:PAGE_W]));
endmodule

bind spi_eeprom_guard spi_eeprom_guard_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .so_en    (so_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .busy     (busy),
    .wel      (wel),
    .lock_en  (lock_en),
    .wp_s     (wp_s),
    .region   (region)
);

// File: tb/spi_eeprom_guard_bench.sv
`timescale 1ns/1ps
module spi_eeprom_guard_bench;
    localparam int ADDR_W = 15;
    localparam int PAGE_W = 6;
    localparam int WR_CYC = 600;
    localparam int HP     = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'hFF;

    always #2 clk = ~clk;

    spi_eeprom_guard #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYC)) u_spi_eeprom_guard (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n), .wp_n(wp_n),
        .so(so), .so_en(so_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    // sparse array model
    logic [7:0] mem [int unsigned];
    int n_wr = 0;
    always @(posedge clk) begin
        if (mem_we) begin
            mem[int'(mem_addr)] = mem_wdata;
            n_wr++;
        end
    end
    always @(negedge clk) begin
        if (mem.exists(int'(mem_addr))) mem_rdata <= mem[int'(mem_addr)];
        else mem_rdata <= 8'hFF;
    end

    int  n_chk = 0, n_err = 0;
    bit  done  = 0;
    bit  mode3 = 0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            tick(HP);
            si = tx[i];
            rx[i] = so;
            sck = 1'b1;
            tick(HP);
        end
    endtask

    task automatic frame_start();
        sck = mode3;
        tick(HP);
        cs_n = 1'b0;
        tick(HP);
    endtask

    task automatic frame_stop();
        if (!mode3) sck = 1'b0;
        tick(HP);
        cs_n = 1'b1;
        tick(HP);
    endtask

    task automatic op1(input logic [7:0] opc);
        logic [7:0] d;
        frame_start(); xfer(opc, d); frame_stop();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        frame_start(); xfer(8'h05, d); xfer(8'h00, s); frame_stop();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        frame_start(); xfer(8'h01, d); xfer(v, d); frame_stop();
    endtask

    task automatic write_n(input logic [14:0] a, input int n, input logic [7:0] first);
        logic [7:0] d;
        frame_start();
        xfer(8'h02, d); xfer({1'b0, a[14:8]}, d); xfer(a[7:0], d);
        for (int i = 0; i < n; i++) xfer(first + 8'(i), d);
        frame_stop();
    endtask

    logic [7:0] rb [4];
    task automatic read_n(input logic [14:0] a, input int n);
        logic [7:0] d;
        frame_start();
        xfer(8'h03, d); xfer({1'b0, a[14:8]}, d); xfer(a[7:0], d);
        for (int i = 0; i < n; i++) xfer(8'h00, rb[i]);
        frame_stop();
    endtask

    task automatic set_status(input logic [7:0] v);
        op1(8'h06); wrsr(v); tick(WR_CYC + 20);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [7:0] s;
        chk("R1 so_en after reset", so_en, 0);
        chk("R1 mem_we after reset", mem_we, 0);
        rdsr(s);
        chk("R1 status after reset", s, 8'h00);
    endtask

    task automatic t_latch();
        logic [7:0] s;
        op1(8'h06); rdsr(s);
        chk("R2 latch set by 0x06", s, 8'h02);
        op1(8'h04); rdsr(s);
        chk("R2 latch cleared by 0x04", s, 8'h00);
    endtask

    task automatic t_no_latch();
        int n0 = n_wr;
        write_n(15'h0100, 2, 8'h55);
        tick(WR_CYC + 20);
        chk("R3 no strobes without latch", n_wr - n0, 0);
        read_n(15'h0100, 1);
        chk("R3 byte unchanged", rb[0], 8'hFF);
    endtask

    task automatic t_page_write();
        logic [7:0] s;
        int n0 = n_wr;
        op1(8'h06);
        write_n(15'h007E, 4, 8'hA0);
        rdsr(s);
        chk("R5 busy right after write", s, 8'h01);
        chk("R7 latch cleared by accepted write", s[1], 0);
        op1(8'h06);
        tick(WR_CYC + 20);
        rdsr(s);
        chk("R5 idle after window and 0x06 ignored while busy", s, 8'h00);
        chk("R12 strobe count", n_wr - n0, 4);
        read_n(15'h007E, 3);
        chk("R4 byte at 0x7E", rb[0], 8'hA0);
        chk("R9 sequential read 0x7F", rb[1], 8'hA1);
        chk("R9 read crosses page to 0x80", rb[2], 8'hFF);
        read_n(15'h0040, 3);
        chk("R4 wrapped byte at 0x40", rb[0], 8'hA2);
        chk("R4 wrapped byte at 0x41", rb[1], 8'hA3);
        chk("R12 unsent byte 0x42 untouched", rb[2], 8'hFF);
    endtask

    task automatic t_mode3();
        mode3 = 1;
        read_n(15'h007E, 2);
        chk("R9 mode 3 read 0x7E", rb[0], 8'hA0);
        chk("R9 mode 3 read 0x7F", rb[1], 8'hA1);
        mode3 = 0;
        sck = 1'b0;
        tick(HP);
    endtask

    task automatic t_hold();
        logic [7:0] d;
        frame_start();
        xfer(8'h03, d); xfer(8'h00, d);
        sck = 1'b0; tick(HP);
        hold_n = 1'b0; tick(4);
        chk("R11 so_en low during pause", so_en, 0);
        si = 1'b1;
        for (int i = 0; i < 6; i++) begin
            sck = 1'b1; tick(HP); sck = 1'b0; tick(HP);
        end
        hold_n = 1'b1; tick(4);
        chk("R11 so_en back after pause", so_en, 1);
        xfer(8'h7E, d);
        xfer(8'h00, d);
        frame_stop();
        chk("R10 paused edges ignored", d, 8'hA0);
    endtask

    task automatic try_write(input string req, input logic [14:0] a, input bit ok);
        logic [7:0] s;
        int n0 = n_wr;
        op1(8'h06);
        write_n(a, 1, 8'h3C);
        rdsr(s);
        chk({req, " busy"}, s[0], ok ? 1 : 0);
        chk("R7 latch cleared after attempt", s[1], 0);
        tick(WR_CYC + 20);
        chk({req, " strobes"}, n_wr - n0, ok ? 1 : 0);
        if (ok) begin
            read_n(a, 1);
            chk({req, " data"}, rb[0], 8'h3C);
        end
    endtask

    task automatic t_region();
        logic [7:0] s;
        set_status(8'h04);
        rdsr(s);
        chk("R8 status write region 1", s, 8'h04);
        try_write("R6 code1 0x0010", 15'h0010, 0);
        try_write("R6 code1 0x0050", 15'h0050, 1);
        set_status(8'h10);
        try_write("R6 code4 0x01FF", 15'h01FF, 0);
        try_write("R6 code4 0x0200", 15'h0200, 1);
        set_status(8'h14);
        try_write("R6 code5 0x1FC0", 15'h1FC0, 0);
        try_write("R6 code5 0x2000", 15'h2000, 1);
        set_status(8'h18);
        try_write("R6 code6 0x3FFF", 15'h3FFF, 0);
        try_write("R6 code6 0x4000", 15'h4000, 1);
        set_status(8'h1C);
        try_write("R6 code7 0x7FC0", 15'h7FC0, 0);
        set_status(8'h00);
    endtask

    task automatic t_lock();
        logic [7:0] s;
        set_status(8'hEB);
        rdsr(s);
        chk("R8 only bits 7 and 4:2 stored", s, 8'h88);
        wp_n = 1'b0;
        set_status(8'h00);
        rdsr(s);
        chk("R8 rejected with pin low", s, 8'h88);
        wp_n = 1'b1;
        set_status(8'h00);
        rdsr(s);
        chk("R8 accepted with pin high", s, 8'h00);
        wp_n = 1'b0;
        set_status(8'h04);
        rdsr(s);
        chk("R8 pin ignored when bit 7 clear", s, 8'h04);
        wp_n = 1'b1;
        set_status(8'h00);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_latch();
        t_no_latch();
        t_page_write();
        t_mode3();
        t_hold();
        t_region();
        t_lock();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule